// File: doc/BRIEF.md
# Serial-In Latched Parallel-Out Register

This block takes a serial bit stream into a chain of shift stages and, on a separate command, copies the whole chain into a holding register that drives a parallel output bus. Shifting and presentation are controlled independently. A new word can therefore be loaded bit by bit while the parallel outputs keep showing the previous word. The new word appears only when a store edge arrives. The last shift stage is also driven out as a serial output, so several instances can be chained, each one passing its oldest bit to the next.

Both the shift and store controls are level inputs, sampled by one system clock. Only a low-to-high transition of each counts as an edge. An active-low clear empties the shift stages at once, without waiting for a clock. It leaves the holding register alone. An active-low output enable chooses between driving the held word and a high-impedance state. The high-impedance state is shown as a per-bit drive-enable bus with the data bus forced low.

Top module: `serial_latch_reg`

## Requirements
- R1: On each detected rising edge of `shift_clk`, stage 0 takes `ser_in` and stage n takes the previous value of stage n-1, for n from 1 to WIDTH-1. The update occurs at the first `clk` edge that samples `shift_clk` high after it was low.
- R2: On each detected rising edge of `store_clk`, all WIDTH shift stages are copied in parallel into the holding register. Stage n appears on `par_q[n]`.
- R3: When both controls rise on the same `clk` edge, the holding register captures the stage values from before that shift. Storage therefore lags the shift chain by one pulse.
- R4: While `clr_n` is low, all shift stages are 0 and `ser_out` is low, with no clock required. Shift edges are ignored while `clr_n` is low and for the SYNC_STAGES (default 2) `clk` edges after its release.
- R5: Clear leaves the holding register unchanged, so the parallel outputs keep the last stored word.
- R6: `ser_out` always equals shift stage WIDTH-1 and does not depend on `oe_n`.
- R7: When `oe_n` is high, `par_drv` is all 0 and `par_q` is all 0. When `oe_n` is low, `par_drv` is all 1 and `par_q` shows the holding register.
- R8: `oe_n` never changes the shift stages or the holding register.
- R9: A store edge without a shift edge leaves the shift stages and `ser_out` unchanged.
- R10: A control held high produces exactly one action. A new action needs a return to low and another rise.
- R11: After `rst_n` is released, the shift stages and the holding register are all 0.
- R12: When one instance's `ser_out` feeds a second instance's `ser_in`, 2*WIDTH shift edges followed by one store edge place the first-sent word in the far instance and the second word in the near one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| shift_clk | input | 1 | Shift control level; a rising transition shifts once |
| store_clk | input | 1 | Store control level; a rising transition copies the stages |
| ser_in | input | 1 | Serial data into stage 0 |
| clr_n | input | 1 | Active-low clear of the shift stages only |
| oe_n | input | 1 | Active-low output enable for the parallel bus |
| ser_out | output | 1 | Cascade output, value of the last shift stage |
| par_q | output | WIDTH | Held word when enabled, zero otherwise |
| par_drv | output | WIDTH | Per-bit drive enable, high when driving |

## Verification
A corrupted shift stage stays hidden on the parallel bus until the next store edge. It reaches `ser_out` only after enough further shift edges to move it to the last stage, up to WIDTH-1 pulses later. With two chained devices, it first appears on the far device's parallel outputs after up to 2*WIDTH shifts and a store. A wrong holding register shows on `par_q` in the cycle after the store, but only while `oe_n` is low. Stimulus therefore alternates long shift runs with frequent stores and output-enable toggles, so that stage errors cannot stay hidden for long.

// File: rtl/slr_pkg.sv
package slr_pkg;
  localparam int unsigned SLR_WIDTH_DEF = 8;
  localparam int unsigned SLR_SYNC_DEF  = 2;
endpackage

// File: rtl/slr_edge_det.sv
module slr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise = lvl & ~prev_q;

  // R10: a held level produces no second strobe
  p_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/slr_rst_sync.sv
module slr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/slr_shift_chain.sv
module slr_shift_chain #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             stage_rst_n,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic [WIDTH-1:0] stages
);
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = shift_en ? ser_in : stage_q[0];
  end

  for (genvar i = 1; i < WIDTH; i++) begin : g_stage
    always_comb begin
      stage_d[i] = shift_en ? stage_q[i-1] : stage_q[i];
    end
  end

  always_ff @(posedge clk or negedge stage_rst_n) begin
    if (!stage_rst_n) stage_q <= '0;
    else              stage_q <= stage_d;
  end

  assign stages = stage_q;

  // R1: one-position move with the serial bit entering at stage 0
  p_shift_r1: assert property (@(posedge clk) disable iff (!stage_rst_n)
    shift_en |=> stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_in)});
  // R9: no shift edge, no change
  p_hold_r9: assert property (@(posedge clk) disable iff (!stage_rst_n)
    !shift_en |=> $stable(stage_q));
endmodule

// File: rtl/slr_store_bank.sv
module slr_store_bank #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store_en,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] stages_in,
  output logic [WIDTH-1:0] par_q,
  output logic [WIDTH-1:0] par_drv
);
  logic [WIDTH-1:0] held_q;
  logic [WIDTH-1:0] held_d;

  always_comb begin
    held_d = store_en ? stages_in : held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_drive
    assign par_drv[b] = ~oe_n;
    assign par_q[b]   = held_q[b] & ~oe_n;
  end

  // R2/R3: the word captured is the stage value present before the edge
  p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |=> held_q == $past(stages_in));
  // R5/R8: without a store edge the held word is kept, whatever clear or oe do
  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !store_en |=> $stable(held_q));
endmodule

// File: rtl/serial_latch_reg.sv
module serial_latch_reg
  import slr_pkg::*;
#(
  parameter int unsigned WIDTH       = SLR_WIDTH_DEF,
  parameter int unsigned SYNC_STAGES = SLR_SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_clk,
  input  logic             store_clk,
  input  logic             ser_in,
  input  logic             clr_n,
  input  logic             oe_n,
  output logic             ser_out,
  output logic [WIDTH-1:0] par_q,
  output logic [WIDTH-1:0] par_drv
);
  localparam int unsigned LAST = WIDTH - 1;

  logic             shift_en;
  logic             store_en;
  logic             chain_arst_n;
  logic             stage_rst_n;
  logic [WIDTH-1:0] stages;

  assign chain_arst_n = rst_n & clr_n;

  slr_edge_det u_shift_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (shift_clk),
    .rise (shift_en)
  );

  slr_edge_det u_store_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (store_clk),
    .rise (store_en)
  );

  slr_rst_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk   (clk),
    .arst_n(chain_arst_n),
    .srst_n(stage_rst_n)
  );

  slr_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk        (clk),
    .stage_rst_n(stage_rst_n),
    .shift_en   (shift_en),
    .ser_in     (ser_in),
    .stages     (stages)
  );

  slr_store_bank #(.WIDTH(WIDTH)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .store_en (store_en),
    .oe_n     (oe_n),
    .stages_in(stages),
    .par_q    (par_q),
    .par_drv  (par_drv)
  );

  assign ser_out = stages[LAST];

  // R4: cascade output low whenever clear is held
  p_clr_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> ser_out == 1'b0);
  // R7: disabled bus is not driven and reads zero
  p_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (par_drv == '0 && par_q == '0));
  // R7: enabled bus drives every bit
  p_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> par_drv == '1);
endmodule

// File: tb/test_serial_latch_reg.sv
module test_serial_latch_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n, shift_clk, store_clk, ser_in, clr_n, oe_n;
  logic ser_mid, ser_far;
  logic [W-1:0] pq_near, pd_near, pq_far, pd_far;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [W-1:0] m_near, m_far, h_near, h_far;

  always #4 clk = ~clk;

  serial_latch_reg i_serial_latch_reg (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .store_clk(store_clk),
    .ser_in(ser_in), .clr_n(clr_n), .oe_n(oe_n), .ser_out(ser_mid),
    .par_q(pq_near), .par_drv(pd_near));

  serial_latch_reg i_far (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .store_clk(store_clk),
    .ser_in(ser_mid), .clr_n(clr_n), .oe_n(oe_n), .ser_out(ser_far),
    .par_q(pq_far), .par_drv(pd_far));

  function automatic logic [2*W-1:0] exp_bus(logic [W-1:0] hf, logic [W-1:0] hn, logic oe);
    return oe ? '0 : {hf, hn};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " par_q"}, {16'h0, pq_far, pq_near}, {16'h0, exp_bus(h_far, h_near, oe_n)});
    chk({req, " par_drv"}, {16'h0, pd_far, pd_near}, oe_n ? 32'h0 : 32'hffff);
    chk({req, " ser_out"}, {30'h0, ser_far, ser_mid}, {30'h0, m_far[W-1], m_near[W-1]});
  endtask

  // one control pulse: levels rise at a negedge, fall at the next
  task automatic pulse(bit do_shift, bit do_store, bit b);
    @(negedge clk);
    ser_in = b; shift_clk = do_shift; store_clk = do_store;
    @(posedge clk);
    if (do_store) begin h_near = m_near; h_far = m_far; end
    if (do_shift) begin
      m_far  = {m_far[W-2:0], m_near[W-1]};
      m_near = {m_near[W-2:0], b};
    end
    @(negedge clk);
    shift_clk = 1'b0; store_clk = 1'b0;
  endtask

  task automatic send_byte(logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) pulse(1'b1, 1'b0, v[i]);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; shift_clk = 0; store_clk = 0; ser_in = 0; clr_n = 1; oe_n = 0;
    m_near = '0; m_far = '0; h_near = '0; h_far = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_all("R11 reset state");

    // R12 cascade: first byte ends in far device
    send_byte(8'hA5);
    send_byte(8'h3C);
    chk({"R9 no store yet"}, {16'h0, pq_far, pq_near}, 32'h0);
    pulse(1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R12 far word", {24'h0, pq_far}, 32'hA5);
    chk("R2 near word", {24'h0, pq_near}, 32'h3C);
    chk_all("R1 after cascade");

    // R3 simultaneous edges
    pulse(1'b1, 1'b1, 1'b1);
    chk("R3 near lags", {24'h0, pq_near}, 32'h3C);
    chk_all("R3 simultaneous");

    // R9 store only leaves stages alone
    pulse(1'b0, 1'b1, 1'b1);
    chk_all("R9 store only");

    // R10 level held high shifts once
    @(negedge clk); ser_in = 1'b1; shift_clk = 1'b1;
    @(posedge clk);
    m_far = {m_far[W-2:0], m_near[W-1]}; m_near = {m_near[W-2:0], 1'b1};
    repeat (5) @(negedge clk);
    shift_clk = 1'b0;
    @(negedge clk);
    pulse(1'b0, 1'b1, 1'b0);
    chk_all("R10 held level");

    // R7/R8 output enable
    @(negedge clk); oe_n = 1'b1;
    @(negedge clk);
    chk_all("R7 hi-z");
    chk("R6 ser_out with oe high", {31'h0, ser_mid}, {31'h0, m_near[W-1]});
    repeat (3) @(negedge clk);
    oe_n = 1'b0;
    @(negedge clk);
    chk_all("R8 oe no effect");

    // R4/R5 clear
    send_byte(8'hFF);
    @(negedge clk); clr_n = 1'b0;
    #1;
    m_near = '0; m_far = '0;
    chk("R4 async ser_out", {30'h0, ser_far, ser_mid}, 32'h0);
    chk("R5 storage kept", {16'h0, pq_far, pq_near}, {16'h0, h_far, h_near});
    @(negedge clk); ser_in = 1'b1; shift_clk = 1'b1;
    @(negedge clk); shift_clk = 1'b0;
    @(negedge clk);
    chk_all("R4 shift ignored in clear");
    pulse(1'b0, 1'b1, 1'b0);
    chk_all("R5 store of cleared stages");
    // release with a shift edge inside the sync window
    @(negedge clk); clr_n = 1'b1; ser_in = 1'b1; shift_clk = 1'b1;
    @(negedge clk); shift_clk = 1'b0;
    @(negedge clk); @(negedge clk);
    chk_all("R4 shift ignored in release window");
    pulse(1'b1, 1'b0, 1'b1);
    pulse(1'b0, 1'b1, 1'b0);
    chk_all("R4 shifting resumes");

    // random mix
    for (int k = 0; k < 400; k++) begin
      int unsigned op;
      op = $urandom_range(0, 9);
      if (op < 5) pulse(1'b1, 1'b0, 1'($urandom_range(0, 1)));
      else if (op < 7) pulse(1'b0, 1'b1, 1'b0);
      else if (op < 8) pulse(1'b1, 1'b1, 1'($urandom_range(0, 1)));
      else begin
        @(negedge clk); oe_n = ~oe_n;
      end
      @(negedge clk);
      chk_all("R1 R2 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule